// File: doc/BRIEF.md
# Single-Accumulator Sign-Magnitude Processor

This block is a small 8-bit processor. It runs a program held in its own 32-word memory and keeps its state in three registers: a program counter, an instruction register and one accumulator. Each instruction takes two phases. In the first, the word at the program counter is loaded into the instruction register and the counter steps forward. In the second, the instruction is decoded and carried out. Every instruction fits in one byte. The upper three bits select the operation and the lower five bits name a memory cell directly.

Integers use sign-magnitude coding: bit 7 is the sign and bits 6..0 are the magnitude. Words enter through a valid/ready input port and leave through a valid/ready output port. While the processor is held in reset, a separate load port fills the memory, and execution then starts at cell 0.

Top module: `sm8_core`

## Requirements
- R1: While reset is asserted, `pc_o` and `acc_o` are 0, and `halted`, `overflow`, `in_ready` and `out_valid` are low.
- R2: Each instruction is fetched from the cell at `pc_o`, after which `pc_o` increases by one. The step from 31 wraps to 0.
- R3: Opcode 000 loads the cell named by the low 5 bits into the accumulator. Opcode 001 writes the accumulator into that cell, and a later fetch of that cell executes the stored word.
- R4: Opcode 010 adds the named cell to the accumulator, and opcode 011 subtracts the named cell from it, both in sign-magnitude. A zero result is always +0 (0x00).
- R5: When a result magnitude exceeds 127, only its low 7 bits are kept and `overflow` is set. `overflow` then stays set until reset.
- R6: Opcode 100 raises `in_ready` and waits until `in_valid` is high. It then copies `in_data` into the accumulator.
- R7: Opcode 101 raises `out_valid` with `out_data` equal to the accumulator. Both hold steady until `out_ready` is high.
- R8: Opcode 110 loads the low 5 bits into the program counter only when the accumulator is negative, which means sign bit set and magnitude nonzero. -0 (0x80) does not branch.
- R9: Opcode 111 raises `halted`. After that the program counter, accumulator and memory stay frozen, and no handshake output is raised, until reset.
- R10: While `load_en` is high, `load_data` is written into the cell at `load_addr` on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Memory preload write strobe |
| load_addr | input | 5 | Preload cell address |
| load_data | input | 8 | Preload word |
| in_valid | input | 1 | Input word available |
| in_data | input | 8 | Input word |
| in_ready | output | 1 | Processor is taking an input word |
| out_valid | output | 1 | Output word available |
| out_data | output | 8 | Output word (accumulator) |
| out_ready | input | 1 | Consumer accepts the output word |
| halted | output | 1 | Stop instruction has executed |
| overflow | output | 1 | Sticky magnitude overflow |
| pc_o | output | 5 | Program counter |
| acc_o | output | 8 | Accumulator |

## Verification
The handshake assertions take two things for granted. First, a pending input or output is completed only by the partner raising its signal. Second, `load_en` is used only while reset is held, so that software writes never race stores made by the running program. The stimulus follows both rules. It preloads programs only during reset and keeps `in_valid` and `in_data` fixed from the falling edge through the next rising edge. It also inserts periodic gaps in `in_valid` and `out_ready`, so that the stall paths are exercised without breaking the handshake rules.

// File: rtl/sm8_pkg.sv
package sm8_pkg;
  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'b000,
    OP_STORE = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_IN    = 3'b100,
    OP_OUT   = 3'b101,
    OP_BNEG  = 3'b110,
    OP_STOP  = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } state_e;
endpackage

// File: rtl/sm8_mem.sv
module sm8_mem #(
  parameter int AW = 5,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [W-1:0]  pre_data,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_waddr,
  input  logic [W-1:0]  cpu_wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  // preload port wins over the running program
  always_ff @(posedge clk) begin
    if (pre_we)      cells[pre_addr]  <= pre_data;
    else if (cpu_we) cells[cpu_waddr] <= cpu_wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sm8_alu.sv
module sm8_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         subtract,
  output logic [W-1:0] result,
  output logic         mag_ovf
);
  localparam int MW = W - 1;

  // returns {overflow, sign, magnitude}
  function automatic logic [W:0] sm_addsub(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic sub);
    logic          sa, sb, sgn, ov;
    logic [MW-1:0] ma, mb, mag;
    logic [MW:0]   sum;
    sa  = a[W-1];
    sb  = b[W-1] ^ sub;
    ma  = a[MW-1:0];
    mb  = b[MW-1:0];
    ov  = 1'b0;
    sum = '0;
    if (sa == sb) begin
      sum = {1'b0, ma} + {1'b0, mb};
      mag = sum[MW-1:0];
      ov  = sum[MW];
      sgn = sa;
    end else if (ma >= mb) begin
      mag = ma - mb;
      sgn = sa;
    end else begin
      mag = mb - ma;
      sgn = sb;
    end
    if (mag == '0) sgn = 1'b0;
    return {ov, sgn, mag};
  endfunction

  assign {mag_ovf, result} = sm_addsub(lhs, rhs, subtract);
endmodule

// File: rtl/sm8_ctrl.sv
module sm8_ctrl
  import sm8_pkg::*;
#(
  parameter int AW = 5,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  alu_result,
  input  logic          alu_ovf,
  output logic          alu_sub,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic          halted,
  output logic          overflow,
  output logic [AW-1:0] pc_o,
  output logic [W-1:0]  acc_o,
  output logic          fetch_fire,
  output logic          branch_taken
);
  localparam logic [AW-1:0] PC_ONE = 1;

  state_e        st;
  logic [AW-1:0] pc;
  logic [W-1:0]  ir, dr;
  logic          ovf;
  op_e           op;
  logic [AW-1:0] arg;
  logic          exec, acc_neg, step_done;

  assign op      = op_e'(ir[W-1:W-OP_W]);
  assign arg     = ir[AW-1:0];
  assign exec    = (st == ST_EXEC);
  assign acc_neg = dr[W-1] && (dr[W-2:0] != '0);

  assign fetch_fire   = (st == ST_FETCH);
  assign branch_taken = exec && (op == OP_BNEG) && acc_neg;
  assign in_ready     = exec && (op == OP_IN);
  assign out_valid    = exec && (op == OP_OUT);
  assign out_data     = dr;
  assign halted       = (st == ST_HALT);
  assign overflow     = ovf;
  assign pc_o         = pc;
  assign acc_o        = dr;

  assign mem_raddr = fetch_fire ? pc : arg;
  assign mem_we    = exec && (op == OP_STORE);
  assign mem_waddr = arg;
  assign mem_wdata = dr;
  assign alu_sub   = (op == OP_SUB);

  assign step_done = exec && !(in_ready && !in_valid) && !(out_valid && !out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_FETCH;
      pc  <= '0;
      ir  <= '0;
      dr  <= '0;
      ovf <= 1'b0;
    end else begin
      case (st)
        ST_FETCH: begin
          ir <= mem_rdata;
          pc <= pc + PC_ONE;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_LOAD: dr <= mem_rdata;
            OP_ADD, OP_SUB: begin
              dr <= alu_result;
              if (alu_ovf) ovf <= 1'b1;
            end
            OP_IN:   if (in_valid) dr <= in_data;
            OP_BNEG: if (acc_neg) pc <= arg;
            default: ;
          endcase
          if (op == OP_STOP)  st <= ST_HALT;
          else if (step_done) st <= ST_FETCH;
        end
        default: ;
      endcase
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> pc == $past(pc) + PC_ONE);

  p_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> pc == $past(arg));

  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(dr) && !in_ready && !out_valid);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready && $stable(dr));
endmodule

// File: rtl/sm8_core.sv
module sm8_core #(
  parameter int AW = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [AW-1:0]            load_addr,
  input  logic [sm8_pkg::OP_W+AW-1:0] load_data,
  input  logic                     in_valid,
  input  logic [sm8_pkg::OP_W+AW-1:0] in_data,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [sm8_pkg::OP_W+AW-1:0] out_data,
  input  logic                     out_ready,
  output logic                     halted,
  output logic                     overflow,
  output logic [AW-1:0]            pc_o,
  output logic [sm8_pkg::OP_W+AW-1:0] acc_o
);
  localparam int W = sm8_pkg::OP_W + AW;

  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [W-1:0]  mem_rdata, mem_wdata, alu_result;
  logic          mem_we, alu_ovf, alu_sub, fetch_fire, branch_taken;

  sm8_mem #(.AW(AW), .W(W)) u_mem (
    .clk       (clk),
    .pre_we    (load_en),
    .pre_addr  (load_addr),
    .pre_data  (load_data),
    .cpu_we    (mem_we),
    .cpu_waddr (mem_waddr),
    .cpu_wdata (mem_wdata),
    .raddr     (mem_raddr),
    .rdata     (mem_rdata)
  );

  sm8_alu #(.W(W)) u_alu (
    .lhs      (acc_o),
    .rhs      (mem_rdata),
    .subtract (alu_sub),
    .result   (alu_result),
    .mag_ovf  (alu_ovf)
  );

  sm8_ctrl #(.AW(AW), .W(W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rdata    (mem_rdata),
    .mem_raddr    (mem_raddr),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata),
    .alu_result   (alu_result),
    .alu_ovf      (alu_ovf),
    .alu_sub      (alu_sub),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ready    (out_ready),
    .halted       (halted),
    .overflow     (overflow),
    .pc_o         (pc_o),
    .acc_o        (acc_o),
    .fetch_fire   (fetch_fire),
    .branch_taken (branch_taken)
  );

  p_plus_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_result[W-2:0] == '0) |-> !alu_result[W-1]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0) && !halted && !overflow && !in_ready && !out_valid);

  p_hs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |-> !in_ready && !out_valid);
endmodule

// File: tb/sm8_core_tb.sv
`timescale 1ns/1ps
module sm8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_ready, halted, overflow;
  logic [7:0] out_data, acc_o;
  logic [4:0] pc_o;

  int errors = 0, checks = 0, cyc = 0;
  bit feed_on = 1'b0;
  int in_idx = 0;
  logic [7:0] in_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  sm8_core u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .halted(halted), .overflow(overflow),
    .pc_o(pc_o), .acc_o(acc_o)
  );

  always #2.5 clk = ~clk;
  initial out_ready = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // drive handshakes on the falling edge; inputs then hold through the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && feed_on) begin
      out_ready = (cyc % 3) != 0;
      if (out_valid && out_ready) got_q.push_back(out_data);
      in_valid = (in_idx < in_q.size()) && ((cyc % 5) != 1);
      in_data  = (in_idx < in_q.size()) ? in_q[in_idx] : 8'h00;
      if (in_valid && in_ready) in_idx++;
    end else begin
      in_valid  = 1'b0;
      out_ready = 1'b0;
    end
  end

  function automatic int sm2i(input logic [7:0] v);
    return v[7] ? -int'(v[6:0]) : int'(v[6:0]);
  endfunction

  // returns {overflow, word}
  function automatic logic [8:0] ref_op(input logic [7:0] a, input logic [7:0] b, input bit sub);
    int r, m;
    r = sm2i(a) + (sub ? -sm2i(b) : sm2i(b));
    m = (r < 0) ? -r : r;
    return {m > 127, (r < 0) && ((m % 128) != 0), 7'(m % 128)};
  endfunction

  task automatic put(input int a, input logic [7:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = 5'(a); load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic reset_phase();
    feed_on = 1'b0;
    rst_n = 1'b0;
    in_q.delete(); exp_q.delete(); got_q.delete(); in_idx = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
    report();
  end

  initial begin
    logic [7:0] vals[14] = '{8'h00, 8'h01, 8'h05, 8'h3F, 8'h40, 8'h64, 8'h7F,
                             8'h80, 8'h81, 8'h85, 8'hBF, 8'hC0, 8'hE4, 8'hFF};
    bit exp_ovf;
    // ---- program 1: read pair, output sum, difference, marker if difference not negative
    reset_phase();
    chk("R1 pc", pc_o, 0); chk("R1 acc", acc_o, 0);
    chk("R1 halted", halted, 0); chk("R1 overflow", overflow, 0);
    chk("R1 in_ready", in_ready, 0); chk("R1 out_valid", out_valid, 0);
    put(0, 8'h80);  put(1, 8'h3E); put(2, 8'h80);  put(3, 8'h3F);
    put(4, 8'h1E);  put(5, 8'h5F); put(6, 8'hA0);  put(7, 8'h1E);
    put(8, 8'h7F);  put(9, 8'hA0); put(10, 8'hCD); put(11, 8'h1C);
    put(12, 8'hA0); put(13, 8'h1D); put(14, 8'hC0);
    put(28, 8'h00); put(29, 8'h81);
    exp_ovf = 1'b0;
    foreach (vals[i]) foreach (vals[j]) begin
      logic [8:0] s, d;
      s = ref_op(vals[i], vals[j], 1'b0);
      d = ref_op(vals[i], vals[j], 1'b1);
      in_q.push_back(vals[i]); in_q.push_back(vals[j]);
      exp_q.push_back(s[7:0]); exp_q.push_back(d[7:0]);
      if (!(d[7] && d[6:0] != 0)) exp_q.push_back(8'h00);
      exp_ovf |= s[8] | d[8];
    end
    @(negedge clk); rst_n = 1'b1; feed_on = 1'b1;
    for (int t = 0; t < 60000 && !(in_idx == in_q.size() && got_q.size() >= exp_q.size()); t++)
      @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R4/R8/R10 output count", got_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      chk("R4/R8 output word", got_q[k], exp_q[k]);
    chk("R5 sticky overflow", overflow, exp_ovf);
    chk("R6 waits for input", in_ready, 1);
    chk("R6 no output while waiting", out_valid, 0);
    chk("R9 not halted", halted, 0);

    // ---- program 2: overflow, -0 branch, wrap, self-modified stop
    reset_phase();
    chk("R1 reset after run pc", pc_o, 0);
    chk("R1 reset clears overflow", overflow, 0);
    put(0, 8'h14); put(1, 8'h54); put(2, 8'hA0); put(3, 8'hDF);
    put(4, 8'h17); put(5, 8'h20); put(6, 8'h18); put(7, 8'hC9);
    put(8, 8'h15); put(9, 8'hA0); put(10, 8'hDF); put(31, 8'hA0);
    put(20, 8'h64); put(21, 8'h85); put(23, 8'hE0); put(24, 8'h80);
    exp_q.push_back(8'h48); exp_q.push_back(8'h85); exp_q.push_back(8'h85);
    @(negedge clk); rst_n = 1'b1; feed_on = 1'b1;
    for (int t = 0; t < 2000 && !halted; t++) @(negedge clk);
    chk("R9 halted", halted, 1);
    chk("R5 overflow after 100+100", overflow, 1);
    chk("R7/R8 output count", got_q.size(), 3);
    for (int k = 0; k < 3 && k < got_q.size(); k++)
      chk("R5/R8 output word", got_q[k], exp_q[k]);
    chk("R2/R3 pc after wrap into stored stop", pc_o, 1);
    chk("R9 acc at stop", acc_o, 8'h85);
    repeat (20) @(negedge clk);
    chk("R9 pc frozen", pc_o, 1);
    chk("R9 acc frozen", acc_o, 8'h85);
    chk("R9 no out_valid", out_valid, 0);
    chk("R9 no in_ready", in_ready, 0);
    chk("R9 no extra output", got_q.size(), 3);
    report();
  end
endmodule